// File: doc/BRIEF.md
# Byte Extract Insert Mask Shifter

This block repositions fields inside a 64-bit word at any byte offset. It is the datapath piece that lets unaligned loads and stores work on aligned quadword memory. A load that spans two quadwords is built from an extract-low of the first quadword ORed with an extract-high of the second. A store is built from insert and mask operations: the new field is placed into each of the two quadwords, and the old bytes are cleared there first.

Four field sizes are supported: byte, word, longword and quadword. Six operations are supported: extract, insert and mask, each in a low and a high form. Only bits 2:0 of operand B are used, and they give the byte offset. The high forms have dedicated zero-offset behaviour, so that for a field that does not cross the quadword boundary the second half contributes nothing. One operation is accepted per cycle over a valid/ready input. The result leaves through a registered valid/ready output one cycle after acceptance.

Back-pressure follows these rules. `in_ready` is high whenever the output register is empty, or its content is being taken in the same cycle. While `out_valid` is high and `out_ready` is low, `out_data` and `out_valid` hold and no new operation is accepted.

Top module: `bxim_shifter`

## Requirements
- R1: Let ofs = `in_b[2:0]`. The shift amount is 8·ofs bits. Bits 63:3 of `in_b` have no effect on the result. The field mask M is the all-ones value of the selected width in the low bits: `in_size` 0 = 8 bits, 1 = 16, 2 = 32, 3 = 64.
- R2: `in_op` 0, extract low: the result is (A >> 8·ofs) & M.
- R3: `in_op` 1, extract high: the result is (A << ((64−8·ofs) mod 64)) & M. With ofs 0 the result is A & M.
- R4: `in_op` 2, insert low: the result is (A & M) << 8·ofs. Bits moved above bit 63 are discarded.
- R5: `in_op` 3, insert high: the result is 0 when ofs is 0. Otherwise it is (A & M) >> (64−8·ofs).
- R6: `in_op` 4, mask low: the result is A & ~(M << 8·ofs).
- R7: `in_op` 5, mask high: the result is A when ofs is 0. Otherwise it is A & ~(M >> (64−8·ofs)).
- R8: The result is 0 for `in_op` 6 or 7, and for `in_op` 1, 3 or 5 when `in_size` is 0 (byte).
- R9: An operation accepted at a clock edge (`in_valid` and `in_ready` both high) shows its result at that edge, with `out_valid` high.
- R10: While `out_valid` is high and `out_ready` is low, `out_valid` and `out_data` hold and `in_ready` is low. `in_ready` is high whenever `out_valid` is low.
- R11: A synchronous reset `rst` clears `out_valid`.
- R12: For any size, ofs and A, insert-low ORed with insert-high of the same operands equals the 128-bit value (A & M) << 8·ofs, split into its low and high quadwords respectively.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Operation can be accepted |
| in_a | input | 64 | Data operand |
| in_b | input | 64 | Offset operand; only bits 2:0 used |
| in_size | input | 2 | Field size: 0 byte, 1 word, 2 longword, 3 quadword |
| in_op | input | 3 | Operation: 0 ext-lo, 1 ext-hi, 2 ins-lo, 3 ins-hi, 4 msk-lo, 5 msk-hi |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_data | output | 64 | Result |

## Verification
The only state is the output register and its valid flag. A fault in the data path therefore shows on `out_data` in the very cycle after the offending operation is accepted. A fault in the flag shows as a missing, repeated or early `out_valid`, or as an `in_ready` that disagrees with the stall rule during the first stalled cycle. An error in the shift-amount arithmetic or the zero-offset handling shows up as wrong bytes only at some offsets and sizes. For that reason every operation, size and offset is swept against a byte-wise model, and the insert pair is rejoined to check the 128-bit split.

// File: rtl/bxim_pkg.sv
package bxim_pkg;
  typedef enum logic [2:0] {
    OP_EXT_LO = 3'd0,
    OP_EXT_HI = 3'd1,
    OP_INS_LO = 3'd2,
    OP_INS_HI = 3'd3,
    OP_MSK_LO = 3'd4,
    OP_MSK_HI = 3'd5
  } bxim_op_e;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_WORD = 2'd1,
    SZ_LONG = 2'd2,
    SZ_QUAD = 2'd3
  } bxim_size_e;
endpackage

// File: rtl/bxim_mask_gen.sv
module bxim_mask_gen #(
  parameter int DATA_W = 64,
  parameter int LANE_W = 8
) (
  input  logic [1:0]        size,
  output logic [DATA_W-1:0] mask
);
  localparam int NSIZE = 4;
  logic [DATA_W-1:0] cand [NSIZE];

  for (genvar s = 0; s < NSIZE; s++) begin : g_sz
    localparam int FW = LANE_W << s;
    if (FW >= DATA_W) begin : g_full
      assign cand[s] = '1;
    end else begin : g_part
      assign cand[s] = {{(DATA_W-FW){1'b0}}, {FW{1'b1}}};
    end
  end

  assign mask = cand[size];
endmodule

// File: rtl/bxim_byte_shift.sv
module bxim_byte_shift #(
  parameter int DATA_W = 64,
  parameter int LANE_W = 8,
  parameter bit LEFT   = 1'b1,
  localparam int OFS_W = $clog2(DATA_W / LANE_W)
) (
  input  logic [DATA_W-1:0] din,
  input  logic [OFS_W-1:0]  amt,
  output logic [DATA_W-1:0] dout
);
  logic [DATA_W-1:0] stage [OFS_W+1];
  assign stage[0] = din;

  for (genvar k = 0; k < OFS_W; k++) begin : g_stage
    localparam int SH = LANE_W << k;
    logic [DATA_W-1:0] moved;
    if (LEFT) begin : g_l
      assign moved = stage[k] << SH;
    end else begin : g_r
      assign moved = stage[k] >> SH;
    end
    assign stage[k+1] = amt[k] ? moved : stage[k];
  end

  assign dout = stage[OFS_W];
endmodule

// File: rtl/bxim_core.sv
module bxim_core
  import bxim_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int LANE_W = 8,
  localparam int OFS_W = $clog2(DATA_W / LANE_W)
) (
  input  logic [DATA_W-1:0] a,
  input  logic [OFS_W-1:0]  ofs,
  input  logic [1:0]        size,
  input  logic [2:0]        op,
  output logic [DATA_W-1:0] res
);
  logic [DATA_W-1:0] m, am;
  logic [OFS_W-1:0]  neg;
  logic              zero_ofs, hi_ok;
  logic [DATA_W-1:0] a_r_ofs, a_l_neg, am_l_ofs, am_r_neg, m_l_ofs, m_r_neg;

  bxim_mask_gen #(.DATA_W(DATA_W), .LANE_W(LANE_W)) u_mask (
    .size(size), .mask(m));

  assign am       = a & m;
  assign neg      = OFS_W'(~ofs + 1'b1);
  assign zero_ofs = (ofs == '0);
  assign hi_ok    = (size != SZ_BYTE);

  bxim_byte_shift #(.DATA_W(DATA_W), .LANE_W(LANE_W), .LEFT(1'b0)) u_s0 (
    .din(a),  .amt(ofs), .dout(a_r_ofs));
  bxim_byte_shift #(.DATA_W(DATA_W), .LANE_W(LANE_W), .LEFT(1'b1)) u_s1 (
    .din(a),  .amt(neg), .dout(a_l_neg));
  bxim_byte_shift #(.DATA_W(DATA_W), .LANE_W(LANE_W), .LEFT(1'b1)) u_s2 (
    .din(am), .amt(ofs), .dout(am_l_ofs));
  bxim_byte_shift #(.DATA_W(DATA_W), .LANE_W(LANE_W), .LEFT(1'b0)) u_s3 (
    .din(am), .amt(neg), .dout(am_r_neg));
  bxim_byte_shift #(.DATA_W(DATA_W), .LANE_W(LANE_W), .LEFT(1'b1)) u_s4 (
    .din(m),  .amt(ofs), .dout(m_l_ofs));
  bxim_byte_shift #(.DATA_W(DATA_W), .LANE_W(LANE_W), .LEFT(1'b0)) u_s5 (
    .din(m),  .amt(neg), .dout(m_r_neg));

  always_comb begin
    res = '0;
    unique case (op)
      OP_EXT_LO: res = a_r_ofs & m;
      OP_EXT_HI: res = hi_ok ? (a_l_neg & m) : '0;
      OP_INS_LO: res = am_l_ofs;
      OP_INS_HI: res = (hi_ok && !zero_ofs) ? am_r_neg : '0;
      OP_MSK_LO: res = a & ~m_l_ofs;
      OP_MSK_HI: res = !hi_ok ? '0 : (zero_ofs ? a : (a & ~m_r_neg));
      default:   res = '0;
    endcase
  end
endmodule

// File: rtl/bxim_out_reg.sv
module bxim_out_reg #(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              up_valid,
  output logic              up_ready,
  input  logic [DATA_W-1:0] up_data,
  output logic              dn_valid,
  input  logic              dn_ready,
  output logic [DATA_W-1:0] dn_data
);
  logic take;
  assign up_ready = !dn_valid || dn_ready;
  assign take     = up_valid && up_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      dn_valid <= 1'b0;
      dn_data  <= '0;
    end else begin
      if (take) begin
        dn_valid <= 1'b1;
        dn_data  <= up_data;
      end else if (dn_ready) begin
        dn_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/bxim_shifter.sv
module bxim_shifter #(
  parameter int DATA_W = 64,
  parameter int LANE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_a,
  input  logic [DATA_W-1:0] in_b,
  input  logic [1:0]        in_size,
  input  logic [2:0]        in_op,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data
);
  localparam int OFS_W = $clog2(DATA_W / LANE_W);

  logic [DATA_W-1:0] res;
  logic              unused_b;
  assign unused_b = ^in_b[DATA_W-1:OFS_W];

  bxim_core #(.DATA_W(DATA_W), .LANE_W(LANE_W)) u_core (
    .a(in_a), .ofs(in_b[OFS_W-1:0]), .size(in_size), .op(in_op), .res(res));

  bxim_out_reg #(.DATA_W(DATA_W)) u_oreg (
    .clk(clk), .rst(rst),
    .up_valid(in_valid), .up_ready(in_ready), .up_data(res),
    .dn_valid(out_valid), .dn_ready(out_ready), .dn_data(out_data));
endmodule

// File: rtl/bxim_chk.sv
module bxim_chk #(
  parameter int DATA_W = 64
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic              in_ready,
  input logic [DATA_W-1:0] in_a,
  input logic [DATA_W-1:0] in_b,
  input logic [1:0]        in_size,
  input logic [2:0]        in_op,
  input logic              out_valid,
  input logic              out_ready,
  input logic [DATA_W-1:0] out_data
);
  // R9
  accept_to_valid_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> out_valid);

  // R10
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  // R10
  stall_block_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |-> !in_ready);

  // R11
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> !out_valid);

  // R8
  bad_op_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && in_op > 3'd5) |=> (out_data == '0));

  // R5
  ins_hi_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && in_op == 3'd3 && in_b[2:0] == 3'd0) |=> (out_data == '0));

  // R7
  msk_hi_pass_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && in_op == 3'd5 && in_size != 2'd0 && in_b[2:0] == 3'd0)
      |=> (out_data == $past(in_a)));
endmodule

bind bxim_shifter bxim_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
  .in_a(in_a), .in_b(in_b), .in_size(in_size), .in_op(in_op),
  .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data));

// File: tb/bxim_shifter_tb.sv
module bxim_shifter_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [63:0] in_a = '0;
  logic [63:0] in_b = '0;
  logic [1:0]  in_size = '0;
  logic [2:0]  in_op = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [63:0] out_data;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  bxim_shifter u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_a(in_a), .in_b(in_b), .in_size(in_size), .in_op(in_op),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data));

  function automatic logic [63:0] model(int op, int sz, int ofs, logic [63:0] a);
    logic [63:0] r = '0;
    int n  = 1 << sz;
    int s2 = (8 - ofs) % 8;
    case (op)
      0: for (int i = 0; i < 8; i++)
           if (i < n && i + ofs < 8) r[8*i +: 8] = a[8*(i+ofs) +: 8];
      1: if (sz != 0)
           for (int i = 0; i < 8; i++)
             if (i < n && i >= s2) r[8*i +: 8] = a[8*(i-s2) +: 8];
      2: for (int j = 0; j < 8; j++)
           if (j >= ofs && j - ofs < n) r[8*j +: 8] = a[8*(j-ofs) +: 8];
      3: if (sz != 0 && ofs != 0)
           for (int j = 0; j < 8; j++)
             if (j + 8 - ofs < n) r[8*j +: 8] = a[8*(j+8-ofs) +: 8];
      4: begin
           r = a;
           for (int j = 0; j < 8; j++)
             if (j >= ofs && j - ofs < n) r[8*j +: 8] = 8'h00;
         end
      5: if (sz != 0) begin
           r = a;
           if (ofs != 0)
             for (int j = 0; j < 8; j++)
               if (j + 8 - ofs < n) r[8*j +: 8] = 8'h00;
         end
      default: r = '0;
    endcase
    return r;
  endfunction

  function automatic string tag(int op, int sz);
    if (op > 5 || (sz == 0 && (op == 1 || op == 3 || op == 5))) return "R8";
    case (op)
      0: return "R2";
      1: return "R3";
      2: return "R4";
      3: return "R5";
      4: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic check(string req, logic [63:0] got, logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // one accepted operation, result sampled at the next falling edge (R9)
  task automatic run_op(int op, int sz, logic [63:0] b, logic [63:0] a,
                        output logic [63:0] res);
    @(negedge clk);
    in_a = a; in_b = b; in_size = 2'(sz); in_op = 3'(op); in_valid = 1'b1;
    @(negedge clk);
    check("R9", {63'b0, out_valid}, 64'd1);
    res = out_data;
    in_valid = 1'b0;
  endtask

  logic [63:0] pats [6] = '{64'h0123456789ABCDEF, 64'hFFFFFFFFFFFFFFFF,
                            64'h8000000000000001, 64'hFEDCBA9876543210,
                            64'hA5A55A5A3C3CC3C3, 64'h00FF00FF00FF00FF};

  initial begin
    logic [63:0] got, lo, hi, b, keep, m;
    logic [127:0] wide;
    repeat (3) @(negedge clk);
    // R11: reset state
    check("R11", {63'b0, out_valid}, 64'd0);
    check("R10", {63'b0, in_ready}, 64'd1);
    rst = 1'b0;

    // main sweep; upper B bits random (R1)
    for (int p = 0; p < 6; p++)
      for (int op = 0; op < 8; op++)
        for (int sz = 0; sz < 4; sz++)
          for (int ofs = 0; ofs < 8; ofs++) begin
            b = {$urandom, $urandom};
            b[2:0] = 3'(ofs);
            run_op(op, sz, b, pats[p], got);
            check(tag(op, sz), got, model(op, sz, ofs, pats[p]));
          end

    // R1: upper B bits all ones versus all zeros
    for (int ofs = 0; ofs < 8; ofs++) begin
      run_op(0, 3, {61'h1FFFFFFFFFFFFFFF, 3'(ofs)}, pats[0], lo);
      run_op(0, 3, {61'h0, 3'(ofs)}, pats[0], hi);
      check("R1", lo, hi);
    end

    // R12: insert pair rejoins into the 128-bit split
    for (int sz = 0; sz < 4; sz++)
      for (int ofs = 0; ofs < 8; ofs++)
        for (int p = 0; p < 6; p++) begin
          m = (sz == 3) ? '1 : ((64'd1 << (8 << sz)) - 64'd1);
          wide = {64'd0, pats[p] & m} << (8 * ofs);
          run_op(2, sz, 64'(ofs), pats[p], lo);
          run_op(3, sz, 64'(ofs), pats[p], hi);
          if (sz != 0) begin
            check("R12", lo | hi, wide[63:0] | wide[127:64]);
            check("R12", hi, wide[127:64]);
          end
          check("R12", lo, wide[63:0]);
        end

    // R10: stall holds output and blocks input
    @(negedge clk);
    out_ready = 1'b0;
    in_a = pats[3]; in_b = 64'd2; in_size = 2'd1; in_op = 3'd0; in_valid = 1'b1;
    @(negedge clk);
    keep = out_data;
    check("R10", keep, model(0, 1, 2, pats[3]));
    in_a = pats[0]; in_op = 3'd4;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      check("R10", {62'b0, out_valid, in_ready}, 64'd2);
      check("R10", out_data, keep);
    end
    out_ready = 1'b1;
    @(negedge clk);
    check("R10", out_data, model(4, 1, 2, pats[0]));
    in_valid = 1'b0;
    @(negedge clk);
    check("R10", {63'b0, out_valid}, 64'd0);

    // R11: reset mid-stream
    in_valid = 1'b1; out_ready = 1'b0;
    @(negedge clk);
    rst = 1'b1; in_valid = 1'b0;
    @(negedge clk);
    check("R11", {63'b0, out_valid}, 64'd0);
    rst = 1'b0; out_ready = 1'b1;
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule